// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two data ports, A and B, and moves data between them in either direction. Each direction has its own storage register. The A-side register captures the A bus, and the B-side register captures the B bus. A capture happens when that direction's capture strobe rises, as seen at the edge of the common system clock.

For the driven port, a per-direction select chooses between two sources:
- the live value on the opposite bus, passed through with no register;
- the stored copy held in that direction's register.

An active-low output enable and a direction input decide which port, if either, is driven. Tri-state pins are modelled as one data vector and one enable flag per port, and the surrounding logic resolves the bus from these.

A test-inhibit input switches off both port enables and freezes both registers, whatever the other controls are doing.

Top module: `bus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both storage registers become zero. After reset, with both selects high, `b_out` and `a_out` read 0.
- R2: With `test_inh` low and `oe_n` high, `a_oe` and `b_oe` are both 0.
- R3: With `test_inh` low, `oe_n` low and `dir` high, `b_oe` is 1 and `a_oe` is 0.
- R4: With `test_inh` low, `oe_n` low and `dir` low, `a_oe` is 1 and `b_oe` is 0.
- R5: With `sel_ab` at 0 (live), `b_out` equals `a_in` in the same cycle, with no register in the path.
- R6: With `sel_ab` at 1 (stored), `b_out` equals the content of the A-side register.
- R7: A capture of the A-side register takes `a_in` at a clock edge where `cap_ab` is 1 and was 0 at the previous edge. At every other edge the register holds its value.
- R8: The B side mirrors R5 to R7. `cap_ba` loads `b_in` into the B-side register on its rising edge. `sel_ba` at 0 gives `a_out` = `b_in`, and `sel_ba` at 1 gives `a_out` = the B-side register.
- R9: Captures take place whatever the values of `oe_n` and `dir`, including while neither port is driven.
- R10: With `test_inh` high, both `a_oe` and `b_oe` are 0 and neither register loads, even on a strobe rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| test_inh | input | 1 | Test inhibit: disables both ports and freezes the registers |
| oe_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive B from A; 0: drive A from B |
| cap_ab | input | 1 | Capture strobe for the A-side register |
| cap_ba | input | 1 | Capture strobe for the B-side register |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B |
| a_in | input | W | Value seen on the A bus |
| b_in | input | W | Value seen on the B bus |
| a_out | output | W | Data presented toward the A bus |
| a_oe | output | 1 | Drive enable for the A bus |
| b_out | output | W | Data presented toward the B bus |
| b_oe | output | 1 | Drive enable for the B bus |

## Verification
The hardest case to reach is a strobe rise that the block must ignore. This happens when the rise coincides with an inhibit cycle, or when the strobe stays high across the end of an inhibit period. In that case the stored value must survive unchanged, and the only way to see it is through the registered path.

Random stimulus toggles the strobes and the inhibit input independently, and holds the selects in stored mode often enough that stale or wrongly loaded contents appear on the outputs. Directed sequences force each of these alignments once. A further directed sequence performs captures while both ports are disabled.

// File: rtl/bxcv_pkg.sv
package bxcv_pkg;
  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_e;

  localparam int unsigned LANES = 2;
  localparam int unsigned LANE_AB = 0;
  localparam int unsigned LANE_BA = 1;
endpackage

// File: rtl/bxcv_edge.sv
module bxcv_edge (
  input  logic clk,
  input  logic strobe,
  output logic rise
);
  logic prev_q;

  // follows the strobe in every cycle, reset included, so a rise is
  // always judged against the preceding sample
  always_ff @(posedge clk) begin
    prev_q <= strobe;
  end

  assign rise = strobe & ~prev_q;
endmodule

// File: rtl/bxcv_store.sv
module bxcv_store #(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (load) begin
      q <= d;
    end
  end
endmodule

// File: rtl/bxcv_lane.sv
module bxcv_lane
  import bxcv_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inh,
  input  logic         cap,
  input  logic         sel,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic         rise;
  logic         load;
  logic [W-1:0] held;
  src_e         src;

  bxcv_edge u_edge (
    .clk    (clk),
    .strobe (cap),
    .rise   (rise)
  );

  assign load = rise & ~inh;

  bxcv_store #(.W(W)) u_store (
    .clk  (clk),
    .rst  (rst),
    .load (load),
    .d    (din),
    .q    (held)
  );

  assign src = src_e'(sel);

  always_comb begin
    unique case (src)
      SRC_HELD: dout = held;
      default:  dout = din;
    endcase
  end
endmodule

// File: rtl/bxcv_dirctl.sv
module bxcv_dirctl (
  input  logic inh,
  input  logic oe_n,
  input  logic dir,
  output logic a_en,
  output logic b_en
);
  logic active;

  assign active = ~inh & ~oe_n;
  assign b_en   = active & dir;
  assign a_en   = active & ~dir;
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr
  import bxcv_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         test_inh,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  logic [LANES-1:0]        lane_cap;
  logic [LANES-1:0]        lane_sel;
  logic [LANES-1:0][W-1:0] lane_in;
  logic [LANES-1:0][W-1:0] lane_out;

  assign lane_cap[LANE_AB] = cap_ab;
  assign lane_cap[LANE_BA] = cap_ba;
  assign lane_sel[LANE_AB] = sel_ab;
  assign lane_sel[LANE_BA] = sel_ba;
  assign lane_in[LANE_AB]  = a_in;
  assign lane_in[LANE_BA]  = b_in;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bxcv_lane #(.W(W)) u_lane (
      .clk  (clk),
      .rst  (rst),
      .inh  (test_inh),
      .cap  (lane_cap[g]),
      .sel  (lane_sel[g]),
      .din  (lane_in[g]),
      .dout (lane_out[g])
    );
  end

  assign b_out = lane_out[LANE_AB];
  assign a_out = lane_out[LANE_BA];

  bxcv_dirctl u_dirctl (
    .inh  (test_inh),
    .oe_n (oe_n),
    .dir  (dir),
    .a_en (a_oe),
    .b_en (b_oe)
  );
endmodule

// File: rtl/bus_xcvr_chk.sv
module bus_xcvr_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst,
  input logic         test_inh,
  input logic         oe_n,
  input logic         dir,
  input logic         cap_ab,
  input logic         cap_ba,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  // R2
  iso_off_chk: assert property (@(posedge clk) disable iff (rst)
    (oe_n && !test_inh) |-> (!a_oe && !b_oe));

  // R3
  drive_b_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && dir && !test_inh) |-> (b_oe && !a_oe));

  // R4
  drive_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!oe_n && !dir && !test_inh) |-> (a_oe && !b_oe));

  // R10
  inh_off_chk: assert property (@(posedge clk) disable iff (rst)
    test_inh |-> (!a_oe && !b_oe));

  // R5
  live_ab_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |-> (b_out == a_in));

  // R8
  live_ba_chk: assert property (@(posedge clk) disable iff (rst)
    !sel_ba |-> (a_out == b_in));

  // R7
  load_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ab && !$past(rst) && !$past(rst, 2) && !$past(test_inh)
     && $past(cap_ab) && !$past(cap_ab, 2)) |-> (b_out == $past(a_in)));

  // R10
  inh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_ab && $past(sel_ab) && $past(test_inh) && !$past(rst))
      |-> $stable(b_out));

  // R1
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && sel_ab && sel_ba) |-> (b_out == '0 && a_out == '0));
endmodule

bind bus_xcvr bus_xcvr_chk #(.W(W)) u_chk (.*);

// File: tb/sim_bus_xcvr.sv
`timescale 1ns/1ps
module sim_bus_xcvr;
  localparam int unsigned W = 18;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         test_inh = 1'b0;
  logic         oe_n = 1'b1;
  logic         dir = 1'b0;
  logic         cap_ab = 1'b0;
  logic         cap_ba = 1'b0;
  logic         sel_ab = 1'b0;
  logic         sel_ba = 1'b0;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] a_out;
  logic         a_oe;
  logic [W-1:0] b_out;
  logic         b_oe;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] m_ra = '0;
  logic [W-1:0] m_rb = '0;
  logic         m_pab = 1'b0;
  logic         m_pba = 1'b0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  bus_xcvr #(.W(W)) u0 (.*);

  function automatic logic exp_b_oe();
    return !test_inh && !oe_n && dir;
  endfunction

  function automatic logic exp_a_oe();
    return !test_inh && !oe_n && !dir;
  endfunction

  function automatic logic [W-1:0] exp_b_out();
    return sel_ab ? m_ra : a_in;
  endfunction

  function automatic logic [W-1:0] exp_a_out();
    return sel_ba ? m_rb : b_in;
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    string en_tag;
    en_tag = test_inh ? "R10" : (oe_n ? "R2" : (dir ? "R3" : "R4"));
    chk(en_tag, W'(a_oe), W'(exp_a_oe()));
    chk(en_tag, W'(b_oe), W'(exp_b_oe()));
    chk(sel_ab ? "R6" : "R5", b_out, exp_b_out());
    chk("R8", a_out, exp_a_out());
  endtask

  // inputs are already settled (driven at the falling edge); check, clock, model
  task automatic cycle();
    #1;
    check_all();
    @(posedge clk);
    if (rst) begin
      m_ra = '0;
      m_rb = '0;
    end else if (!test_inh) begin
      if (cap_ab && !m_pab) m_ra = a_in;
      if (cap_ba && !m_pba) m_rb = b_in;
    end
    m_pab = cap_ab;
    m_pba = cap_ba;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    a_in = 18'h3ABCD;
    b_in = 18'h1F0F0;
    cycle();
    cycle();
    rst = 1'b0;
    sel_ab = 1'b1;
    sel_ba = 1'b1;
    #1;
    // R1: registers cleared by reset
    chk("R1", b_out, '0);
    chk("R1", a_out, '0);
    @(negedge clk);

    // R7: rising strobe captures A; held value survives later A changes
    a_in = 18'h2AAAA;
    cap_ab = 1'b1;
    cycle();
    cap_ab = 1'b1;
    a_in = 18'h15555;
    cycle();
    #1 chk("R7", b_out, 18'h2AAAA);
    @(negedge clk);

    // R9: capture while both ports isolated; R8 for the B side
    oe_n = 1'b1;
    cap_ba = 1'b1;
    b_in = 18'h0C3C3;
    cycle();
    b_in = 18'h00001;
    cycle();
    #1 chk("R9", a_out, 18'h0C3C3);
    chk("R2", W'(a_oe | b_oe), '0);
    @(negedge clk);

    // R10: strobe rise under inhibit is ignored; staying high afterwards also ignored
    cap_ab = 1'b0;
    cycle();
    test_inh = 1'b1;
    oe_n = 1'b0;
    cap_ab = 1'b1;
    a_in = 18'h3FFFF;
    cycle();
    test_inh = 1'b0;
    cycle();
    #1 chk("R10", b_out, 18'h2AAAA);
    @(negedge clk);

    // R5 / R3: live path same cycle
    sel_ab = 1'b0;
    dir = 1'b1;
    a_in = 18'h12345;
    #1 chk("R5", b_out, 18'h12345);
    chk("R3", W'(b_oe), W'(1'b1));
    @(negedge clk);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      test_inh = ($urandom_range(7) == 0);
      oe_n     = $urandom_range(1);
      dir      = $urandom_range(1);
      cap_ab   = $urandom_range(1);
      cap_ba   = $urandom_range(1);
      sel_ab   = ($urandom_range(3) != 0);
      sel_ba   = ($urandom_range(3) != 0);
      a_in     = W'($urandom);
      b_in     = W'($urandom);
      rst      = ($urandom_range(199) == 0);
      cycle();
    end
    rst = 1'b0;
    cycle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule